// File: doc/BRIEF.md
# Serial Clock Generator with Two Divide Laws

This block derives the serial clock of a serial-peripheral master from the module clock. One select input picks the divide law. The linear law uses an 8-bit count and runs the serial clock at the module rate divided by twice the count plus one. The power-of-two law uses a 4-bit exponent and runs the serial clock at the module rate divided by two raised to the exponent plus one. Either law sets a half-period of H module cycles: H = count + 1 for the linear law and H = 2^exponent for the power-of-two law.

The transfer engine holds `run` high for as long as a transfer lasts. While `run` is low, the serial clock rests at the level that the polarity input gives, and the divider counter is held at zero. Each new transfer therefore begins with a full-length half-period. The block also gives the shift engine two one-cycle strobes. The launch strobe marks when the next bit should be driven and the sample strobe marks when the incoming bit should be captured. The phase input decides which serial-clock edge plays which role.

Top module: `sclk_gen`

## Requirements
- R1: While `run` is low, and in the cycle after it falls, `sck` equals `cpol` and both `launch` and `sample` are 0. The same holds after reset.
- R2: With `lin_sel` = 1, `sck` changes level every `lin_div` + 1 cycles while `run` is high.
- R3: With `lin_sel` = 0, `sck` changes level every 2^`exp_div` cycles while `run` is high.
- R4: `lin_sel` = 1 selects the linear law and `lin_sel` = 0 selects the power-of-two law. The same field values give different periods under the two settings.
- R5: Counting the first rising clock edge with `run` high as cycle 1, the first `sck` change is seen after cycle H. This holds again after `run` drops in mid-transfer and rises again.
- R6: With `cpha` = 0, `sample` pulses in the cycle `sck` takes its leading (away-from-idle) edge. `launch` pulses in cycle 1 of a transfer and in every cycle `sck` takes its trailing edge.
- R7: With `cpha` = 1, `launch` pulses on each leading edge of `sck` and `sample` pulses on each trailing edge.
- R8: With `lin_sel` = 1 and `lin_div` = 0, `sck` changes every module cycle, which is half the module clock rate.
- R9: The leading-edge strobe and the trailing-edge strobe each last one cycle and are never high in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High while a transfer is in progress |
| lin_sel | input | 1 | 1 selects the linear law, 0 the power-of-two law |
| lin_div | input | 8 | Linear divide count |
| exp_div | input | 4 | Power-of-two exponent |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| sck | output | 1 | Serial clock pin |
| launch | output | 1 | One-cycle strobe: drive the next bit |
| sample | output | 1 | One-cycle strobe: capture the incoming bit |

## Verification
The bench sweeps both divide laws over all four polarity and phase pairs. Linear counts of 0, 1, 2 and 5 separate the fastest case from the general formula. Exponents 0 through 6 tell a shift law apart from a linear one, and the extreme values 255 and 15 exercise the full counter width. Running the same field values under both select settings exposes a reversed or ignored select bit. A transfer cut short in mid half-period and then restarted shows whether the counter and the clock phase really return to their initial state. Each cycle's `sck`, `launch` and `sample` values are compared against a cycle count computed from H, so a half-period that is off by one or a swapped strobe role is caught.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  typedef struct packed {
    logic lead;
    logic trail;
  } edge_strb_t;

  function automatic int half_width(input int lin_w, input int exp_w);
    int pw;
    pw = 2 ** exp_w;
    return (pw > lin_w + 1) ? pw : lin_w + 1;
  endfunction
endpackage

// File: rtl/sclk_half_sel.sv
module sclk_half_sel #(
  parameter int LIN_W  = 8,
  parameter int EXP_W  = 4,
  parameter int HALF_W = 16
) (
  input  logic              lin_sel,
  input  logic [LIN_W-1:0]  lin_div,
  input  logic [EXP_W-1:0]  exp_div,
  output logic [HALF_W-1:0] half
);
  always_comb begin
    if (lin_sel) half = HALF_W'(lin_div) + HALF_W'(1);
    else         half = HALF_W'(1) << exp_div;
  end
endmodule

// File: rtl/sclk_half_cnt.sv
module sclk_half_cnt #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q >= half - HALF_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + HALF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: an idle cycle leaves the counter at zero for the next start
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/sclk_phase.sv
module sclk_phase
  import sclk_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic cpol,
  input  logic cpha,
  output logic sck,
  output logic launch,
  output logic sample
);
  logic       phase_q, phase_d;
  logic       run_q;
  logic       start_q, start_d;
  edge_strb_t strb_q, strb_d;

  always_comb begin
    phase_d     = phase_q;
    strb_d.lead  = 1'b0;
    strb_d.trail = 1'b0;
    start_d     = run && !run_q;
    if (!run) begin
      phase_d = 1'b0;
    end else if (tick) begin
      phase_d      = ~phase_q;
      strb_d.lead  = !phase_q;
      strb_d.trail = phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      run_q   <= 1'b0;
      start_q <= 1'b0;
      strb_q  <= '0;
    end else begin
      phase_q <= phase_d;
      run_q   <= run;
      start_q <= start_d;
      strb_q  <= strb_d;
    end
  end

  assign sck    = cpol ^ phase_q;
  assign launch = cpha ? strb_q.lead : (strb_q.trail | start_q);
  assign sample = cpha ? strb_q.trail : strb_q.lead;

  // R1: clock phase returns to idle once the transfer stops
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !phase_q);
  // R2: every counter tick moves the clock to its other level
  p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase_q != $past(phase_q)));
  // R9: strobes are single-cycle pulses
  p_lead_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q.lead |=> !strb_q.lead);
  p_trail_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q.trail |=> !strb_q.trail);
  // R6: a leading strobe follows the clock leaving idle
  p_lead_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q.lead |-> (phase_q && !$past(phase_q)));
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_gen_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             lin_sel,
  input  logic [LIN_W-1:0] lin_div,
  input  logic [EXP_W-1:0] exp_div,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sck,
  output logic             launch,
  output logic             sample
);
  localparam int HALF_W = half_width(LIN_W, EXP_W);

  logic [HALF_W-1:0] half;
  logic              tick;

  sclk_half_sel #(.LIN_W(LIN_W), .EXP_W(EXP_W), .HALF_W(HALF_W)) u_sel (
    .lin_sel (lin_sel),
    .lin_div (lin_div),
    .exp_div (exp_div),
    .half    (half)
  );

  sclk_half_cnt #(.HALF_W(HALF_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .half  (half),
    .tick  (tick)
  );

  sclk_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .tick   (tick),
    .cpol   (cpol),
    .cpha   (cpha),
    .sck    (sck),
    .launch (launch),
    .sample (sample)
  );
endmodule

// File: tb/sim_sclk_gen.sv
module sim_sclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       lin_sel = 1'b1;
  logic [7:0] lin_div = '0;
  logic [3:0] exp_div = '0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       sck, launch, sample;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .lin_sel(lin_sel),
    .lin_div(lin_div), .exp_div(exp_div), .cpol(cpol), .cpha(cpha),
    .sck(sck), .launch(launch), .sample(sample)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_idle(input bit pol, input string tag);
    check(sck == pol, tag, "idle sck", int'(sck), int'(pol));
    check(launch == 1'b0, tag, "idle launch", int'(launch), 0);
    check(sample == 1'b0, tag, "idle sample", int'(sample), 0);
  endtask

  // Runs one transfer for ncyc cycles and compares every cycle.
  task automatic run_cfg(input bit sel, input int a, input int b,
                         input bit pol, input bit pha, input int ncyc,
                         input string sck_tag);
    int h;
    h = sel ? a + 1 : (1 << b);
    lin_sel = sel; lin_div = 8'(a); exp_div = 4'(b);
    cpol = pol; cpha = pha; run = 1'b0;
    step(); step();
    check_idle(pol, "R1");
    run = 1'b1;
    for (int k = 1; k <= ncyc; k++) begin
      int q; bit ph, edg, ld, tr, st, exp_l, exp_s;
      string t;
      step();
      q = k / h; ph = q[0]; edg = (k % h) == 0;
      ld = edg && ph; tr = edg && !ph && (q > 0); st = (k == 1);
      exp_l = pha ? ld : (tr | st);
      exp_s = pha ? tr : ld;
      t = (k <= h) ? "R5" : sck_tag;
      check(sck == (pol ^ ph), t, "sck", int'(sck), int'(pol ^ ph));
      check(launch == exp_l, pha ? "R7" : "R6", "launch", int'(launch), int'(exp_l));
      check(sample == exp_s, pha ? "R7" : "R6", "sample", int'(sample), int'(exp_s));
      if (edg) check(!(launch && sample && k > 1 && pha), "R9", "both strobes", 1, 0);
    end
    run = 1'b0;
    step();
    check_idle(pol, "R1");
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step();
    check(sck == 1'b0, "R1", "reset sck", int'(sck), 0);
    check(launch == 1'b0 && sample == 1'b0, "R1", "reset strobes",
          int'({launch, sample}), 0);
    rst_n = 1'b1;
    step();
    for (int p = 0; p < 4; p++) begin
      run_cfg(1'b1, 0, 0, p[1], p[0], 8, "R8");
      run_cfg(1'b1, 1, 0, p[1], p[0], 12, "R2");
      run_cfg(1'b1, 2, 0, p[1], p[0], 18, "R2");
      run_cfg(1'b1, 5, 0, p[1], p[0], 36, "R2");
      for (int b = 0; b <= 6; b++)
        run_cfg(1'b0, 0, b, p[1], p[0], 4 * (1 << b), "R3");
    end
    // R4: identical field values, both select settings
    run_cfg(1'b1, 2, 2, 1'b0, 1'b0, 24, "R4");
    run_cfg(1'b0, 2, 2, 1'b0, 1'b0, 24, "R4");
    // R5: cut short in mid half-period, then restart
    run_cfg(1'b1, 3, 0, 1'b1, 1'b0, 6, "R5");
    run_cfg(1'b1, 3, 0, 1'b1, 1'b0, 16, "R5");
    // extremes of both fields
    run_cfg(1'b1, 255, 0, 1'b0, 1'b1, 3 * 256, "R2");
    run_cfg(1'b0, 0, 15, 1'b1, 1'b1, 32769, "R3");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule